// File: doc/BRIEF.md
# ADPCM Nibble Decoder

This block turns a stream of packed 4-bit ADPCM codes into 16-bit unsigned audio samples. Each input byte carries two codes. The decoder keeps a predictor, which is the most recent decoded sample, and an index into a step-size table. For every code it scales the step size by the code's three magnitude bits and adds that delta to the predictor or subtracts it, according to the code's sign bit. The result is clipped to the unsigned 16-bit range. The index then moves by an amount chosen from the magnitude.

A consumer pulses `req` once for each sample it wants. A decode of the low nibble first pulls a new byte from the upstream source through a valid/ready handshake. The following request decodes the high nibble of the same byte, which is held inside the block, and does not touch the source. Each finished decode raises `sample_valid` for one clock, and `sample_data` then holds the new value. A pulse on `start` restarts the stream state without a full reset. The step-size table is computed at elaboration and read through a registered ROM.

Top module: `adpcm_nibble_dec`

## Requirements
- R1: After `rst` or a `start` pulse, the step index is 0, the predictor and `sample_data` are 32768, the next decode uses a low nibble, and `sample_valid` and `byte_ready` are low. When `start` and `req` arrive in the same cycle, `start` wins and the request is dropped.
- R2: A low-nibble decode takes bits 3:0 of a byte accepted with `byte_valid && byte_ready` and keeps bits 7:4. The next request decodes those kept bits without raising `byte_ready`, so no byte is taken for it.
- R3: With magnitude m = code bits 2:0, the delta is floor((2·m + 1) · step[index] / 16).
- R4: When code bit 3 is 1, the new sample is the predictor minus the delta, floored at 0.
- R5: When code bit 3 is 0, the new sample is the predictor plus the delta, capped at 65535.
- R6: After each code, the index changes by −1 for m = 0..3 and by +2, +4, +6 or +8 for m = 4, 5, 6 or 7.
- R7: The index is clamped to the range 0..88 inclusive.
- R8: The step table is defined as follows. step[0] = 7. step[i+1] = min(32767, max(step[i] + 1, step[i] + floor((step[i] + 5) / 10))). step[88] = 32767.
- R9: A request sampled while idle with a high nibble pending gives `sample_valid` at the next rising edge. With a low nibble due, `byte_ready` is high from the next edge until a byte is accepted, and `sample_valid` follows at the edge after the acceptance.
- R10: `sample_valid` is high for exactly one clock per decode, and `sample_data` holds the last decoded sample until the next decode.
- R11: A `req` that arrives while a decode is under way is ignored. It produces no extra sample and no extra byte fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart pulse; clears the index, the predictor and the nibble phase |
| req | input | 1 | Request for one decoded sample |
| byte_data | input | 8 | Packed byte holding two codes, low nibble first |
| byte_valid | input | 1 | Upstream byte present |
| byte_ready | output | 1 | Decoder takes the byte this cycle |
| sample_data | output | 16 | Latest decoded sample |
| sample_valid | output | 1 | One-clock strobe for a new sample |

## Verification
The bench drives long runs of the all-positive code 7 and the all-negative code 15, so the predictor pins at 65535 and then at 0 while the index stays at 88. A design whose sum or difference wrapped would show a sudden jump to the far rail. Long runs of code 0 hold the index at its lower bound, where a missing clamp would wrap the index and read a huge step. Between bytes the bench offers a byte during high-nibble decodes, restarts in the middle of a byte, and holds `req` across a busy decode. A design that fetched on every request, kept the nibble phase across a restart, or counted a held request twice would then emit wrong values, raise `byte_ready` when it should not, or produce an extra strobe. A near-exhaustive pseudo-random sweep checks every sample against an arithmetic model and visits the whole index range.

// File: rtl/adpcm_dec_pkg.sv
package adpcm_dec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_CALC  = 2'd2
  } dec_state_e;

  // Step size for table position idx; the last position is pinned to the top value.
  function automatic int step_entry(input int idx, input int last);
    int s;
    s = 7;
    for (int i = 0; i < idx; i++) begin
      int g;
      g = (11 * s + 5) / 10;
      if (g < s + 1) g = s + 1;
      if (g > 32767) g = 32767;
      s = g;
    end
    if (idx == last) s = 32767;
    return s;
  endfunction

  // Index movement chosen by the three magnitude bits of a code.
  function automatic logic signed [4:0] idx_adjust(input logic [2:0] mag);
    case (mag)
      3'd4:    idx_adjust = 5'sd2;
      3'd5:    idx_adjust = 5'sd4;
      3'd6:    idx_adjust = 5'sd6;
      3'd7:    idx_adjust = 5'sd8;
      default: idx_adjust = -5'sd1;
    endcase
  endfunction

endpackage

// File: rtl/adpcm_step_rom.sv
module adpcm_step_rom
  import adpcm_dec_pkg::*;
#(
  parameter int DEPTH  = 89,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data_q
);

  logic [DATA_W-1:0] rom_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign rom_w[g] = DATA_W'(step_entry(g, DEPTH - 1));
  end

  // Registered read so the table maps onto a synchronous ROM.
  always_ff @(posedge clk) begin
    data_q <= (int'(addr) < DEPTH) ? rom_w[addr] : '0;
  end

endmodule

// File: rtl/adpcm_sample_update.sv
module adpcm_sample_update
  import adpcm_dec_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int STEP_W   = 16,
  parameter int IDX_MAX  = 88,
  localparam int IDX_W   = $clog2(IDX_MAX + 1)
) (
  input  logic [3:0]          code,
  input  logic [SAMPLE_W-1:0] prev,
  input  logic [STEP_W-1:0]   step,
  input  logic [IDX_W-1:0]    index,
  output logic [SAMPLE_W-1:0] next_sample,
  output logic [IDX_W-1:0]    next_index
);

  logic [2:0]          mag;
  logic [STEP_W+3:0]   prod;
  logic [STEP_W-1:0]   delta;
  logic [SAMPLE_W:0]   delta_x;
  logic [SAMPLE_W:0]   sum;
  logic signed [4:0]   adj;
  logic [IDX_W+1:0]    idx_sum;

  assign mag     = code[2:0];
  assign prod    = (STEP_W+4)'({mag, 1'b1}) * (STEP_W+4)'(step);
  assign delta   = STEP_W'(prod >> 4);
  assign delta_x = (SAMPLE_W+1)'(delta);
  assign sum     = {1'b0, prev} + delta_x;
  assign adj     = idx_adjust(mag);
  assign idx_sum = {2'b00, index} + {{(IDX_W-3){adj[4]}}, adj};

  always_comb begin
    if (code[3]) begin
      next_sample = (delta_x > {1'b0, prev}) ? '0 : (prev - SAMPLE_W'(delta));
    end else begin
      next_sample = sum[SAMPLE_W] ? '1 : sum[SAMPLE_W-1:0];
    end
  end

  always_comb begin
    if (idx_sum[IDX_W+1]) begin
      next_index = '0;
    end else if (idx_sum[IDX_W:0] > (IDX_W+1)'(IDX_MAX)) begin
      next_index = IDX_W'(IDX_MAX);
    end else begin
      next_index = idx_sum[IDX_W-1:0];
    end
  end

  always_comb begin
    assert_floor_R4: assert (!code[3] || next_sample <= prev);
    assert_cap_R5: assert (code[3] || next_sample >= prev);
    assert_idx_bound_R7: assert (int'(next_index) <= IDX_MAX);
  end

endmodule

// File: rtl/adpcm_nibble_dec.sv
module adpcm_nibble_dec
  import adpcm_dec_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int STEP_W   = 16,
  parameter int IDX_MAX  = 88,
  localparam int IDX_W   = $clog2(IDX_MAX + 1),
  localparam logic [SAMPLE_W-1:0] MID_SAMPLE = SAMPLE_W'(1) << (SAMPLE_W - 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                req,
  input  logic [7:0]          byte_data,
  input  logic                byte_valid,
  output logic                byte_ready,
  output logic [SAMPLE_W-1:0] sample_data,
  output logic                sample_valid
);

  dec_state_e          state_q;
  logic                phase_hi_q;
  logic [3:0]          hi_code_q;
  logic [3:0]          code_q;
  logic [IDX_W-1:0]    index_q;
  logic [SAMPLE_W-1:0] pred_q;
  logic                valid_q;
  logic [STEP_W-1:0]   step_q;
  logic [SAMPLE_W-1:0] next_sample;
  logic [IDX_W-1:0]    next_index;

  adpcm_step_rom #(
    .DEPTH  (IDX_MAX + 1),
    .DATA_W (STEP_W)
  ) u_rom (
    .clk    (clk),
    .addr   (index_q),
    .data_q (step_q)
  );

  adpcm_sample_update #(
    .SAMPLE_W (SAMPLE_W),
    .STEP_W   (STEP_W),
    .IDX_MAX  (IDX_MAX)
  ) u_update (
    .code        (code_q),
    .prev        (pred_q),
    .step        (step_q),
    .index       (index_q),
    .next_sample (next_sample),
    .next_index  (next_index)
  );

  always_ff @(posedge clk) begin
    if (rst || start) begin
      state_q    <= ST_IDLE;
      phase_hi_q <= 1'b0;
      hi_code_q  <= '0;
      code_q     <= '0;
      index_q    <= '0;
      pred_q     <= MID_SAMPLE;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req) begin
            if (phase_hi_q) begin
              code_q  <= hi_code_q;
              state_q <= ST_CALC;
            end else begin
              state_q <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (byte_valid) begin
            code_q    <= byte_data[3:0];
            hi_code_q <= byte_data[7:4];
            state_q   <= ST_CALC;
          end
        end
        ST_CALC: begin
          pred_q     <= next_sample;
          index_q    <= next_index;
          valid_q    <= 1'b1;
          phase_hi_q <= ~phase_hi_q;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign byte_ready   = (state_q == ST_FETCH);
  assign sample_data  = pred_q;
  assign sample_valid = valid_q;

  assert_start_clear_R1: assert property (@(posedge clk) disable iff (rst)
    start |=> (index_q == '0 && pred_q == MID_SAMPLE && !sample_valid && !byte_ready));

  assert_hi_no_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && req && phase_hi_q && !start) |=> !byte_ready);

  assert_index_range_R7: assert property (@(posedge clk) disable iff (rst)
    int'(index_q) <= IDX_MAX);

  assert_take_to_calc_R9: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_ready && !start) |=> (state_q == ST_CALC));

  assert_calc_emits_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CALC && !start) |=> sample_valid);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  assert_busy_ignores_req_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CALC && req && !start) |=> (state_q == ST_IDLE));

endmodule

// File: tb/adpcm_nibble_dec_tb.sv
`timescale 1ns/1ps
module adpcm_nibble_dec_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       req = 1'b0;
  logic [7:0] byte_data = '0;
  logic       byte_valid = 1'b0;
  logic       byte_ready;
  logic [15:0] sample_data;
  logic       sample_valid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int m_step [89];
  int m_idx;
  int m_pred;
  bit m_hi;
  int m_hi_code;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  adpcm_nibble_dec u_dut (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .req          (req),
    .byte_data    (byte_data),
    .byte_valid   (byte_valid),
    .byte_ready   (byte_ready),
    .sample_data  (sample_data),
    .sample_valid (sample_valid)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  task automatic model_reset();
    m_idx = 0;
    m_pred = 32768;
    m_hi = 0;
  endtask

  task automatic model_code(input int c);
    int mag, d, a;
    mag = c & 7;
    d = ((2 * mag + 1) * m_step[m_idx]) / 16;
    if ((c & 8) != 0) m_pred = (m_pred - d < 0) ? 0 : m_pred - d;
    else              m_pred = (m_pred + d > 65535) ? 65535 : m_pred + d;
    a = (mag < 4) ? -1 : (mag - 3) * 2;
    m_idx = m_idx + a;
    if (m_idx < 0) m_idx = 0;
    if (m_idx > 88) m_idx = 88;
  endtask

  task automatic decode(input logic [7:0] b, input string rq, input bit hold);
    bit fetch;
    int c;
    fetch = !m_hi;
    if (fetch) begin
      c = int'(b[3:0]);
      m_hi_code = int'(b[7:4]);
    end else begin
      c = m_hi_code;
    end
    model_code(c);
    m_hi = !m_hi;
    @(negedge clk);
    req = 1'b1;
    byte_valid = 1'b1;
    byte_data = b;
    @(negedge clk);
    if (!hold) req = 1'b0;
    chk(byte_ready == fetch, fetch ? "R9" : "R2", "byte_ready after request", int'(byte_ready), int'(fetch));
    if (fetch) begin
      @(negedge clk);
      byte_valid = 1'b0;
      chk(sample_valid == 1'b0, "R9", "early sample_valid", int'(sample_valid), 0);
    end else begin
      byte_valid = 1'b0;
    end
    @(negedge clk);
    req = 1'b0;
    chk(sample_valid == 1'b1, "R9", "sample_valid", int'(sample_valid), 1);
    chk(int'(sample_data) == m_pred, rq, "sample_data", int'(sample_data), m_pred);
    @(negedge clk);
    chk(sample_valid == 1'b0 && byte_ready == 1'b0, hold ? "R11" : "R10",
        "strobe/ready after sample", int'({sample_valid, byte_ready}), 0);
  endtask

  task automatic do_start(input bit with_req);
    @(negedge clk);
    start = 1'b1;
    req = with_req;
    @(negedge clk);
    start = 1'b0;
    req = 1'b0;
    model_reset();
    chk(byte_ready == 1'b0 && sample_valid == 1'b0, "R1", "ready/valid after start",
        int'({byte_ready, sample_valid}), 0);
    chk(int'(sample_data) == 32768, "R1", "sample after start", int'(sample_data), 32768);
  endtask

  function automatic logic [7:0] next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[7:0] ^ lfsr[23:16];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    m_step[0] = 7;
    for (int i = 1; i < 89; i++) begin
      int n;
      n = m_step[i-1] + (m_step[i-1] + 5) / 10;
      if (n < m_step[i-1] + 1) n = m_step[i-1] + 1;
      if (n > 32767) n = 32767;
      m_step[i] = n;
    end
    m_step[88] = 32767;
    model_reset();

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sample_valid == 1'b0 && byte_ready == 1'b0, "R1", "ready/valid after reset",
        int'({sample_valid, byte_ready}), 0);
    chk(int'(sample_data) == 32768, "R1", "sample after reset", int'(sample_data), 32768);

    // R6/R7 lower clamp: code 0 keeps the index at 0
    for (int i = 0; i < 8; i++) decode(8'h00, "R7", 1'b0);
    // R5 and R7 upper side: positive maximum codes pin the sample at 65535
    for (int i = 0; i < 60; i++) decode(8'h77, "R5", 1'b0);
    // R4: negative maximum codes floor at 0
    for (int i = 0; i < 60; i++) decode(8'hFF, "R4", 1'b0);
    // mixed magnitudes per nibble, R6
    for (int i = 0; i < 16; i++) decode(8'((i << 4) | (15 - i)), "R6", 1'b0);

    // R1: restart mid-byte (high nibble pending), start beats a request
    decode(8'h3A, "R3", 1'b0);
    do_start(1'b1);
    decode(8'h5C, "R1", 1'b0);
    decode(8'hEE, "R2", 1'b0);

    // R11: request held high through busy decodes
    decode(8'h46, "R11", 1'b1);
    decode(8'h99, "R11", 1'b1);

    // R3/R8 near-exhaustive sweep over codes and the whole index range
    do_start(1'b0);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] b;
      b = next_rand();
      if (i % 400 < 40) b = 8'h77;
      else if (i % 400 < 60) b = 8'h0F;
      decode(b, "R8", 1'b0);
    end

    summary();
    $finish;
  end

endmodule